// File: doc/BRIEF.md
# Converter Control and Result Register Block

This block is the digital half of an eight-channel, 8-bit successive-approximation converter as an 8-bit processor sees it. Software uses two byte registers on a simple synchronous bus. The control byte holds a power enable, a 3-bit input selector, a self-clearing start strobe and a read-only completion flag. The result byte is read-only and holds the last finished conversion.

A start request is accepted only when the enable bit is set and no conversion is running. The block then latches the input selector onto the analog multiplexer select lines and spends one cycle sampling. It then resolves the code from the most significant bit down, one bit per cycle. In each of those cycles it drives a trial code to an external DAC and reads an external comparator. Software writes the start bit and polls the completion flag until it returns to 1, then reads the result.

Top module: `adc_ctrl_if`

## Requirements
- R1: After reset the control byte at address 0xEA reads 0x01, `pwr_down` is 1 and `mux_sel` is 0.
- R2: The control byte is at address 0xEA and the result byte at 0xEB. Any other address reads 0x00, and a write to it changes nothing. Writes to 0xEB are ignored. Control bits 7:6 always read 0.
- R3: In the control byte, bit 5 is the enable and bits 4:2 are the channel code. Both can be written and read back. `pwr_down` equals the inverse of the enable bit.
- R4: Writing 1 to control bit 1 with bit 5 set starts a conversion. Bit 1 then reads 1 for exactly the cycle after the write and 0 afterwards. Writing 0 to bit 1 starts nothing.
- R5: Control bit 0 is the completion flag. It reads 0 from the cycle after an accepted start until the conversion ends, and 1 otherwise.
- R6: The comparator input `cmp_in` is 1 when the selected analog level is at or above `dac_code`. The result is the 8-bit code found by testing bits MSB first, keeping each trial bit only when `cmp_in` is 1.
- R7: The result byte and the completion flag change on the same clock edge, nine edges after the write edge that started the conversion.
- R8: A start written while the enable bit (as written) is 0 is ignored. Bit 1 stays 0, the flag stays 1 and no sample cycle occurs.
- R9: A start written during a conversion is ignored, and the running conversion finishes with an unchanged result.
- R10: `mux_sel` takes the channel code when a start is accepted and holds it until the next accepted start, even if the channel field is rewritten.
- R11: Writing the enable bit to 0 during a conversion aborts it on that edge. The flag reads 1, `pwr_down` is 1 and the result byte keeps its previous value.
- R12: `sample_hold` is 1 for exactly one cycle, the cycle after an accepted start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 8 | Register byte address |
| bus_we | input | 1 | Write strobe, one write per cycle |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr`, combinational |
| mux_sel | output | 3 | Analog multiplexer select, latched at start |
| sample_hold | output | 1 | Sample/hold strobe |
| dac_code | output | 8 | Trial code to the DAC, 0 when not converting |
| cmp_in | input | 1 | Comparator decision for the current trial code |
| pwr_down | output | 1 | Converter power-down request |

## Verification
Take E as the write edge of an accepted start. The start bit and `sample_hold` are due in the cycle just after E. The completion flag must read 0 in the eighth cycle after that one. The flag and the result are due together after edge E+9. Disable and ignored-write effects appear right after their own write edge. The bench drives inputs on the falling edge and samples 1 ns after a falling edge. A monitor counts falling edges from the observed sample pulse to the exact cycle each result is due. The analog model answers the comparator from a per-channel level, so each expected code equals the level the bench queued.

// File: rtl/adc_ctrl_pkg.sv
package adc_ctrl_pkg;
   typedef enum logic [1:0] {
      SEQ_IDLE   = 2'd0,
      SEQ_SAMPLE = 2'd1,
      SEQ_CONV   = 2'd2
   } seq_state_e;

   localparam int DONE_POS  = 0;
   localparam int START_POS = 1;
   localparam int CH_POS    = 2;
endpackage

// File: rtl/adc_reg_decode.sv
module adc_reg_decode #(
   parameter int ADDR_W    = 8,
   parameter int CTRL_ADDR = 'hEA,
   parameter int RES_ADDR  = 'hEB
) (
   input  logic [ADDR_W-1:0] addr,
   input  logic              we,
   output logic              sel_ctrl,
   output logic              sel_res,
   output logic              ctrl_wr
);
   localparam logic [ADDR_W-1:0] CTRL_A = ADDR_W'(CTRL_ADDR);
   localparam logic [ADDR_W-1:0] RES_A  = ADDR_W'(RES_ADDR);

   if (CTRL_A == RES_A) begin : g_bad_map
      $error("control and result addresses must differ");
   end

   assign sel_ctrl = (addr == CTRL_A);
   assign sel_res  = (addr == RES_A);
   assign ctrl_wr  = we && sel_ctrl;
endmodule

// File: rtl/adc_ctrl_regs.sv
module adc_ctrl_regs #(
   parameter int CH_W = 3
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            ctrl_wr,
   input  logic            wr_en_bit,
   input  logic            wr_start_bit,
   input  logic [CH_W-1:0] wr_ch,
   input  logic            busy,
   output logic            en_q,
   output logic            en_nxt,
   output logic [CH_W-1:0] ch_q,
   output logic            start_q,
   output logic            start_acc
);
   assign en_nxt    = ctrl_wr ? wr_en_bit : en_q;
   assign start_acc = ctrl_wr && wr_start_bit && wr_en_bit && !busy;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en_q    <= 1'b0;
         ch_q    <= '0;
         start_q <= 1'b0;
      end else begin
         en_q    <= en_nxt;
         start_q <= start_acc;
         if (ctrl_wr) ch_q <= wr_ch;
      end
   end
endmodule

// File: rtl/adc_sar_seq.sv
module adc_sar_seq
   import adc_ctrl_pkg::*;
#(
   parameter int RES_W = 8,
   parameter int CH_W  = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             en_nxt,
   input  logic             start,
   input  logic [CH_W-1:0]  ch_in,
   input  logic             cmp_in,
   output logic             busy,
   output logic             done_q,
   output logic [RES_W-1:0] res_q,
   output logic [RES_W-1:0] dac_code,
   output logic [CH_W-1:0]  mux_sel,
   output logic             sample
);
   localparam int IDX_W = (RES_W > 1) ? $clog2(RES_W) : 1;

   if (RES_W < 2) begin : g_bad_res
      $error("RES_W must be at least 2");
   end

   seq_state_e       state;
   logic [IDX_W-1:0] bit_idx;
   logic [RES_W-1:0] sar_q;
   logic [RES_W-1:0] trial;
   logic [RES_W-1:0] decided;
   logic [CH_W-1:0]  chan_q;

   for (genvar i = 0; i < RES_W; i++) begin : g_bit
      assign trial[i]   = (bit_idx == IDX_W'(i)) ? 1'b1   : sar_q[i];
      assign decided[i] = (bit_idx == IDX_W'(i)) ? cmp_in : sar_q[i];
   end

   assign busy     = (state != SEQ_IDLE);
   assign sample   = (state == SEQ_SAMPLE);
   assign dac_code = (state == SEQ_CONV) ? trial : '0;
   assign mux_sel  = chan_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state   <= SEQ_IDLE;
         bit_idx <= '0;
         sar_q   <= '0;
         chan_q  <= '0;
         done_q  <= 1'b1;
         res_q   <= '0;
      end else if (!en_nxt) begin
         state  <= SEQ_IDLE;
         done_q <= 1'b1;
      end else begin
         case (state)
            SEQ_IDLE: begin
               if (start) begin
                  state  <= SEQ_SAMPLE;
                  chan_q <= ch_in;
                  sar_q  <= '0;
                  done_q <= 1'b0;
               end
            end
            SEQ_SAMPLE: begin
               state   <= SEQ_CONV;
               bit_idx <= IDX_W'(RES_W - 1);
            end
            SEQ_CONV: begin
               sar_q <= decided;
               if (bit_idx == '0) begin
                  res_q  <= decided;
                  done_q <= 1'b1;
                  state  <= SEQ_IDLE;
               end else begin
                  bit_idx <= bit_idx - 1'b1;
               end
            end
            default: state <= SEQ_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/adc_ctrl_if.sv
module adc_ctrl_if
   import adc_ctrl_pkg::*;
#(
   parameter int ADDR_W    = 8,
   parameter int BUS_W     = 8,
   parameter int RES_W     = 8,
   parameter int CH_W      = 3,
   parameter int CTRL_ADDR = 'hEA,
   parameter int RES_ADDR  = 'hEB
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic              bus_we,
   input  logic [BUS_W-1:0]  bus_wdata,
   output logic [BUS_W-1:0]  bus_rdata,
   output logic [CH_W-1:0]   mux_sel,
   output logic              sample_hold,
   output logic [RES_W-1:0]  dac_code,
   input  logic              cmp_in,
   output logic              pwr_down
);
   localparam int EN_POS = CH_POS + CH_W;
   localparam logic [BUS_W-1:0] LIVE_MASK = BUS_W'(((1 << (EN_POS + 1)) - 1) & ~1);

   if (EN_POS >= BUS_W) begin : g_bad_ctrl
      $error("control fields do not fit in BUS_W");
   end
   if (RES_W > BUS_W) begin : g_bad_width
      $error("RES_W must not exceed BUS_W");
   end

   logic             sel_ctrl, sel_res, ctrl_wr;
   logic             en_q, en_nxt, start_q, start_acc;
   logic [CH_W-1:0]  ch_q;
   logic             busy, done_q;
   logic [RES_W-1:0] res_q;
   logic [BUS_W-1:0] ctrl_byte;
   logic [BUS_W-1:0] res_byte;
   logic             unused_wbits;

   assign unused_wbits = ^(bus_wdata & ~LIVE_MASK);

   adc_reg_decode #(
      .ADDR_W(ADDR_W), .CTRL_ADDR(CTRL_ADDR), .RES_ADDR(RES_ADDR)
   ) u_dec (
      .addr(bus_addr), .we(bus_we),
      .sel_ctrl(sel_ctrl), .sel_res(sel_res), .ctrl_wr(ctrl_wr)
   );

   adc_ctrl_regs #(.CH_W(CH_W)) u_regs (
      .clk(clk), .rst_n(rst_n), .ctrl_wr(ctrl_wr),
      .wr_en_bit(bus_wdata[EN_POS]), .wr_start_bit(bus_wdata[START_POS]),
      .wr_ch(bus_wdata[CH_POS +: CH_W]), .busy(busy),
      .en_q(en_q), .en_nxt(en_nxt), .ch_q(ch_q),
      .start_q(start_q), .start_acc(start_acc)
   );

   adc_sar_seq #(.RES_W(RES_W), .CH_W(CH_W)) u_seq (
      .clk(clk), .rst_n(rst_n), .en_nxt(en_nxt), .start(start_acc),
      .ch_in(bus_wdata[CH_POS +: CH_W]), .cmp_in(cmp_in),
      .busy(busy), .done_q(done_q), .res_q(res_q),
      .dac_code(dac_code), .mux_sel(mux_sel), .sample(sample_hold)
   );

   always_comb begin
      ctrl_byte                   = '0;
      ctrl_byte[DONE_POS]         = done_q;
      ctrl_byte[START_POS]        = start_q;
      ctrl_byte[CH_POS +: CH_W]   = ch_q;
      ctrl_byte[EN_POS]           = en_q;
   end

   if (RES_W == BUS_W) begin : g_res_full
      assign res_byte = res_q;
   end else begin : g_res_ext
      assign res_byte = {{(BUS_W - RES_W){1'b0}}, res_q};
   end

   assign bus_rdata = sel_ctrl ? ctrl_byte : (sel_res ? res_byte : '0);
   assign pwr_down  = !en_q;
endmodule

// File: rtl/adc_ctrl_checker.sv
module adc_ctrl_checker #(
   parameter int RES_W = 8,
   parameter int CH_W  = 3
) (
   input logic             clk,
   input logic             rst_n,
   input logic             en_q,
   input logic             start_q,
   input logic             busy,
   input logic             done_q,
   input logic [RES_W-1:0] res_q,
   input logic [CH_W-1:0]  mux_sel,
   input logic             sample_hold
);
   AST_START_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
      start_q |=> !start_q); // R4

   AST_START_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
      start_q |-> en_q); // R8

   AST_OFF_MEANS_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      !en_q |-> (!busy && done_q)); // R11

   AST_BUSY_NOT_DONE: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> !done_q); // R5

   AST_RESULT_WITH_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
      (res_q != $past(res_q)) |-> $rose(done_q)); // R7

   AST_MUX_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && $past(busy)) |-> $stable(mux_sel)); // R10

   AST_SAMPLE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
      sample_hold |=> !sample_hold); // R12
endmodule

bind adc_ctrl_if adc_ctrl_checker #(.RES_W(RES_W), .CH_W(CH_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .en_q(en_q), .start_q(start_q), .busy(busy),
   .done_q(done_q), .res_q(res_q), .mux_sel(mux_sel), .sample_hold(sample_hold)
);

// File: tb/test_adc_ctrl_if.sv
module test_adc_ctrl_if;
   localparam logic [7:0] CTRL = 8'hEA;
   localparam logic [7:0] RES  = 8'hEB;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [7:0] drv_addr, bus_addr, bus_wdata, bus_rdata, dac_code;
   logic       bus_we, mon_rd, sample_hold, pwr_down, cmp_in;
   logic [2:0] mux_sel;
   logic [7:0] vin [8];

   always #10 clk = ~clk;

   assign bus_addr = mon_rd ? RES : drv_addr;
   assign cmp_in   = (vin[mux_sel] >= dac_code);

   adc_ctrl_if i_adc_ctrl_if (
      .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .mux_sel(mux_sel),
      .sample_hold(sample_hold), .dac_code(dac_code), .cmp_in(cmp_in),
      .pwr_down(pwr_down)
   );

   typedef struct {
      logic [2:0] ch;
      logic [7:0] val;
   } exp_t;

   exp_t q[$];
   int   n_chk = 0, n_fail = 0, pushed = 0, finished = 0;
   bit   ended = 1'b0;

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
      end
   endtask

   task automatic finish_run();
      if (!ended) begin
         ended = 1'b1;
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   endtask

   task automatic rd(input logic [7:0] a, output logic [7:0] d);
      drv_addr = a;
      #1;
      d = bus_rdata;
      drv_addr = CTRL;
   endtask

   task automatic wr(input logic [7:0] a, input logic [7:0] d);
      @(negedge clk);
      drv_addr  = a;
      bus_wdata = d;
      bus_we    = 1'b1;
      @(negedge clk);
      bus_we    = 1'b0;
      drv_addr  = CTRL;
      #1;
   endtask

   function automatic logic [7:0] ctl(input bit en, input logic [2:0] ch,
                                      input bit st, input bit dn);
      return {2'b00, en, ch, st, dn};
   endfunction

   task automatic conv(input logic [2:0] ch, input logic [7:0] v);
      logic [7:0] d;
      exp_t it;
      vin[ch] = v;
      it.ch = ch;
      it.val = v;
      q.push_back(it);
      pushed++;
      wr(CTRL, ctl(1, ch, 1, 0));
      rd(CTRL, d);
      chk(d == ctl(1, ch, 1, 0), "R4 start bit set, R5 flag low", d, ctl(1, ch, 1, 0));
      @(negedge clk); #1;
      rd(CTRL, d);
      chk(d == ctl(1, ch, 0, 0), "R4 start bit self-clear", d, ctl(1, ch, 0, 0));
      wait (finished == pushed);
      rd(CTRL, d);
      chk(d == ctl(1, ch, 0, 1), "R5 flag back to complete", d, ctl(1, ch, 0, 1));
   endtask

   // Monitor: pops the expected item at each observed sample pulse
   initial begin
      mon_rd = 1'b0;
      forever begin
         @(negedge clk); #1;
         if (sample_hold && q.size() > 0) begin
            exp_t it;
            it = q.pop_front();
            chk(mux_sel == it.ch, "R10 channel latched", mux_sel, it.ch);
            @(negedge clk); #1;
            chk(sample_hold == 1'b0, "R12 single sample cycle", sample_hold, 0);
            repeat (7) @(negedge clk);
            #1;
            chk(bus_rdata[0] == 1'b0, "R5 flag low in last bit cycle", bus_rdata[0], 0);
            @(negedge clk); #1;
            chk(bus_rdata[0] == 1'b1, "R7 flag set at result edge", bus_rdata[0], 1);
            chk(mux_sel == it.ch, "R10 channel held", mux_sel, it.ch);
            mon_rd = 1'b1;
            #1;
            chk(bus_rdata == it.val, "R6 R7 result", bus_rdata, it.val);
            mon_rd = 1'b0;
            finished++;
         end
      end
   end

   initial begin
      repeat (200000) @(posedge clk);
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual 0x0 expected 0x1");
      finish_run();
   end

   initial begin
      logic [7:0] d;
      drv_addr = CTRL; bus_wdata = '0; bus_we = 1'b0;
      for (int i = 0; i < 8; i++) vin[i] = '0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk); #1;

      rd(CTRL, d);
      chk(d == 8'h01, "R1 control reset", d, 8'h01);
      chk(pwr_down == 1'b1, "R1 power-down at reset", pwr_down, 1);
      chk(mux_sel == 3'd0, "R1 mux at reset", mux_sel, 0);

      rd(8'h00, d);
      chk(d == 8'h00, "R2 unmapped read", d, 0);
      wr(8'h10, 8'hFF);
      rd(CTRL, d);
      chk(d == 8'h01, "R2 unmapped write ignored", d, 8'h01);
      wr(CTRL, 8'hC0);
      rd(CTRL, d);
      chk(d == 8'h01, "R2 reserved bits read zero", d, 8'h01);

      wr(CTRL, 8'h02);
      chk(sample_hold == 1'b0, "R8 no sample when disabled", sample_hold, 0);
      rd(CTRL, d);
      chk(d == 8'h01, "R8 start ignored when disabled", d, 8'h01);

      wr(CTRL, 8'h3C);
      chk(sample_hold == 1'b0, "R4 writing start 0 starts nothing", sample_hold, 0);
      rd(CTRL, d);
      chk(d == 8'h3D, "R3 fields read back", d, 8'h3D);
      chk(pwr_down == 1'b0, "R3 powered up", pwr_down, 0);

      conv(3'd0, 8'h00);
      conv(3'd7, 8'hFF);
      conv(3'd3, 8'h80);
      conv(3'd4, 8'h7F);
      conv(3'd5, 8'h5A);
      conv(3'd1, 8'hA5);

      wr(RES, 8'h00);
      rd(RES, d);
      chk(d == 8'hA5, "R2 result write ignored", d, 8'hA5);

      // start and channel change during a running conversion
      begin
         exp_t it;
         vin[6] = 8'h3C;
         vin[2] = 8'hC3;
         it.ch = 3'd6;
         it.val = 8'h3C;
         q.push_back(it);
         pushed++;
         wr(CTRL, ctl(1, 3'd6, 1, 0));
         repeat (2) @(negedge clk);
         wr(CTRL, ctl(1, 3'd2, 1, 0));
         rd(CTRL, d);
         chk(d == ctl(1, 3'd2, 0, 0), "R9 start ignored while busy", d, ctl(1, 3'd2, 0, 0));
         wait (finished == pushed);
         chk(mux_sel == 3'd6, "R10 field change not applied", mux_sel, 6);
      end

      // abort by clearing enable
      vin[2] = 8'h99;
      wr(CTRL, ctl(1, 3'd2, 1, 0));
      repeat (2) @(negedge clk);
      wr(CTRL, ctl(0, 3'd2, 0, 0));
      rd(CTRL, d);
      chk(d == ctl(0, 3'd2, 0, 1), "R11 abort sets flag", d, ctl(0, 3'd2, 0, 1));
      chk(pwr_down == 1'b1, "R11 powered down", pwr_down, 1);
      chk(dac_code == 8'h00, "R11 no trial code", dac_code, 0);
      repeat (10) @(negedge clk);
      #1;
      rd(RES, d);
      chk(d == 8'h3C, "R11 result kept", d, 8'h3C);

      conv(3'd2, 8'hC3);

      repeat (3) @(negedge clk);
      finish_run();
   end
endmodule